// File: doc/BRIEF.md
# Feistel Round Datapath with Keyed Mixing Insertions

This block is the data side of a 64-bit block cipher. It has one combinational round unit and one 64-bit state register. An external sequencer drives it one round per clock. On each step, a four-way source selector picks what enters the round. The choices are the whitened input word, the held state, the held state passed through a keyed mixing function, or the held state passed through that function's exact inverse. The round result can be written to the state register, and it can also be written to a 64-bit output register after output whitening.

A complete block takes eleven clocks. The first step loads the input; steps 5 and 8 route the state through the forward and inverse mixing functions; the eleventh step captures the ciphertext. Decryption uses the same eleven-step schedule. The sequencer reverses the round key order, exchanges the input and output whitening keys, and raises `decrypt`. With `decrypt` high, both mixing paths act on the half-swapped view of the state, which is how the register holds it while unwinding the rounds.

Top module: `fstl_core`

## Requirements
- R1: A synchronous active-high `rst` clears both the state register and `dout` to zero.
- R2: With `src_sel`=0 (load), the round input is `din ^ kw_pre`. The left half is bits 63:32 and the right half is bits 31:0 everywhere.
- R3: A round maps halves (L,R) to (R ^ F(L,K), L), where K is `round_key`.
- R4: F(x,K) applies the byte substitution to each byte of x, then the mix, then XORs K. For the mix, take bytes a0..a3 with a0 = x[31:24]. Output byte i is 02·a(i) ^ 03·a(i+1) ^ a(i+2) ^ a(i+3), with indices mod 4 and products over GF(2^8) modulo 0x11B. Output byte 0 lands in bits 31:24.
- R5: The byte substitution takes the multiplicative inverse in that field, with 0 mapping to 0. It then applies b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63. For example, 00 maps to 63 and 01 maps to 7C.
- R6: With `src_sel`=1, the round input is the held state.
- R7: With `src_sel`=2 and `decrypt`=0, the round input is the forward mix of the state (L,R), computed in two steps. First R' = R ^ rotl1(L & `kfa1`). Then L' = L ^ (rotr1(R') & `kfa2`).
- R8: With `src_sel`=3 and `decrypt`=0, the round input is the inverse mix. First L = L' ^ (rotr1(R') & `kfa2`). Then R = R' ^ rotl1(L & `kfa1`). The inverse mix undoes the forward mix for every state.
- R9: With `decrypt`=1, selects 2 and 3 swap the halves, apply the forward or inverse mix, and swap the halves back.
- R10: When `out_en` is high, `dout` takes the round result with its halves swapped, XORed with `kw_post`, at the same clock edge. When `out_en` is low, `dout` holds.
- R11: When `step_en` is low, the state register holds its value.
- R12: The full schedule is: load at step 1, forward mix at step 5, inverse mix at step 8, and output capture at step 11. Decryption reverses the key order, exchanges `kw_pre` and `kw_post`, and sets `decrypt`. Run that way, decryption returns the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 64 | Input block |
| src_sel | input | 2 | Round source: 0 load, 1 state, 2 forward mix, 3 inverse mix |
| step_en | input | 1 | Write round result to state |
| out_en | input | 1 | Capture whitened round result on dout |
| decrypt | input | 1 | Mixing paths act on the half-swapped state |
| round_key | input | 32 | Round subkey for this step |
| kfa1 | input | 32 | First mixing key |
| kfa2 | input | 32 | Second mixing key |
| kw_pre | input | 64 | Input whitening key (left, right) |
| kw_post | input | 64 | Output whitening key (left, right) |
| dout | output | 64 | Registered output block |

## Verification
The substitution table is buried behind the mix and the key XOR, so it is hard to observe from the ports. The bench loads a word made of four copies of one byte with zero keys. For such a word the mix coefficients cancel, so the right half of `dout` shows the substituted byte four times. Sweeping all 256 byte values checks the whole table. The swapped-view mixing paths only matter in the middle of a decryption, so the bench also sets `decrypt` in single steps from a known state and checks each step. It then runs full encrypt and decrypt round trips.

// File: rtl/fstl_pkg.sv
package fstl_pkg;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 32;
    localparam int BLK_W  = 2 * HALF_W;
    localparam int NBYTE  = HALF_W / BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef struct packed {
        half_t left;
        half_t right;
    } blk_t;

    typedef enum logic [1:0] {
        SRC_LOAD = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_MIX  = 2'd2,
        SRC_UNMX = 2'd3
    } src_e;

    function automatic byte_t xtime(byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gmul(byte_t a, byte_t b);
        byte_t p = '0;
        byte_t t = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ t;
            t = xtime(t);
        end
        return p;
    endfunction

    // a^254 is the field inverse (0 stays 0)
    function automatic byte_t ginv(byte_t a);
        byte_t r = 8'h01;
        byte_t base = a;
        logic [7:0] e = 8'd254;
        for (int i = 0; i < BYTE_W; i++) begin
            if (e[i]) r = gmul(r, base);
            base = gmul(base, base);
        end
        return r;
    endfunction

    function automatic byte_t rotb(byte_t b, int n);
        return byte_t'((b << n) | (b >> (BYTE_W - n)));
    endfunction

    function automatic byte_t subst(byte_t a);
        byte_t v = ginv(a);
        return v ^ rotb(v, 1) ^ rotb(v, 2) ^ rotb(v, 3) ^ rotb(v, 4) ^ 8'h63;
    endfunction

    function automatic half_t mix(half_t x);
        half_t y = '0;
        for (int i = 0; i < NBYTE; i++) begin
            y[HALF_W-1-BYTE_W*i -: BYTE_W] =
                gmul(x[HALF_W-1-BYTE_W*i -: BYTE_W], 8'h02) ^
                gmul(x[HALF_W-1-BYTE_W*((i+1)%NBYTE) -: BYTE_W], 8'h03) ^
                x[HALF_W-1-BYTE_W*((i+2)%NBYTE) -: BYTE_W] ^
                x[HALF_W-1-BYTE_W*((i+3)%NBYTE) -: BYTE_W];
        end
        return y;
    endfunction

    function automatic half_t rotl1(half_t h);
        return {h[HALF_W-2:0], h[HALF_W-1]};
    endfunction

    function automatic half_t rotr1(half_t h);
        return {h[0], h[HALF_W-1:1]};
    endfunction

    function automatic blk_t swap_h(blk_t b);
        return '{left: b.right, right: b.left};
    endfunction

    function automatic blk_t fwd_mix(blk_t x, half_t k1, half_t k2);
        blk_t y;
        y.right = x.right ^ rotl1(x.left & k1);
        y.left  = x.left ^ (rotr1(y.right) & k2);
        return y;
    endfunction

    function automatic blk_t inv_mix(blk_t y, half_t k1, half_t k2);
        blk_t x;
        x.left  = y.left ^ (rotr1(y.right) & k2);
        x.right = y.right ^ rotl1(x.left & k1);
        return x;
    endfunction
endpackage

// File: rtl/fstl_sbox.sv
module fstl_sbox
    import fstl_pkg::*;
(
    input  logic [BYTE_W-1:0] a,
    output logic [BYTE_W-1:0] y
);
    assign y = subst(a);
endmodule

// File: rtl/fstl_round_fn.sv
module fstl_round_fn
    import fstl_pkg::*;
(
    input  logic [HALF_W-1:0] x,
    input  logic [HALF_W-1:0] key,
    output logic [HALF_W-1:0] y
);
    half_t subbed;

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        fstl_sbox u_sb (
            .a (x[HALF_W-1-BYTE_W*b -: BYTE_W]),
            .y (subbed[HALF_W-1-BYTE_W*b -: BYTE_W])
        );
    end

    assign y = mix(subbed) ^ key;
endmodule

// File: rtl/fstl_src_mux.sv
module fstl_src_mux
    import fstl_pkg::*;
(
    input  logic [BLK_W-1:0]  din_w,
    input  logic [BLK_W-1:0]  state,
    input  logic [HALF_W-1:0] kfa1,
    input  logic [HALF_W-1:0] kfa2,
    input  logic              decrypt,
    input  logic [1:0]        sel,
    output logic [BLK_W-1:0]  y
);
    blk_t view, fwd_o, inv_o;

    // decryption holds the state half-swapped; mix in that view
    assign view  = decrypt ? swap_h(blk_t'(state)) : blk_t'(state);
    assign fwd_o = fwd_mix(view, kfa1, kfa2);
    assign inv_o = inv_mix(view, kfa1, kfa2);

    always_comb begin
        case (src_e'(sel))
            SRC_LOAD: y = din_w;
            SRC_HOLD: y = state;
            SRC_MIX:  y = decrypt ? swap_h(fwd_o) : fwd_o;
            default:  y = decrypt ? swap_h(inv_o) : inv_o;
        endcase
    end
endmodule

// File: rtl/fstl_core.sv
module fstl_core
    import fstl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [63:0]       din,
    input  logic [1:0]        src_sel,
    input  logic              step_en,
    input  logic              out_en,
    input  logic              decrypt,
    input  logic [31:0]       round_key,
    input  logic [31:0]       kfa1,
    input  logic [31:0]       kfa2,
    input  logic [63:0]       kw_pre,
    input  logic [63:0]       kw_post,
    output logic [63:0]       dout
);
    blk_t  state_q, dout_q, src_blk, rnd_blk;
    half_t f_out;
    logic [BLK_W-1:0] src_raw;

    fstl_src_mux u_mux (
        .din_w   (din ^ kw_pre),
        .state   (state_q),
        .kfa1    (kfa1),
        .kfa2    (kfa2),
        .decrypt (decrypt),
        .sel     (src_sel),
        .y       (src_raw)
    );
    assign src_blk = blk_t'(src_raw);

    fstl_round_fn u_f (
        .x   (src_blk.left),
        .key (round_key),
        .y   (f_out)
    );

    assign rnd_blk = '{left: src_blk.right ^ f_out, right: src_blk.left};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            dout_q  <= '0;
        end else begin
            if (step_en) state_q <= rnd_blk;
            if (out_en)  dout_q  <= blk_t'(swap_h(rnd_blk) ^ kw_post);
        end
    end

    assign dout = dout_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (dout == '0 && state_q == '0));

    // R11
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(state_q));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable(dout));

    // R8
    mix_roundtrip_chk: assert property (@(posedge clk) disable iff (rst)
        inv_mix(fwd_mix(state_q, kfa1, kfa2), kfa1, kfa2) == state_q);
endmodule

// File: tb/fstl_core_bench.sv
module fstl_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] din = '0;
    logic [1:0]  src_sel = '0;
    logic        step_en = 1'b0;
    logic        out_en = 1'b0;
    logic        decrypt = 1'b0;
    logic [31:0] round_key = '0;
    logic [31:0] kfa1 = '0;
    logic [31:0] kfa2 = '0;
    logic [63:0] kw_pre = '0;
    logic [63:0] kw_post = '0;
    logic [63:0] dout;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_state = '0;
    logic [63:0] m_dout = '0;
    logic [31:0] ks [11];

    always #4 clk = ~clk;

    fstl_core u_fstl_core (
        .clk(clk), .rst(rst), .din(din), .src_sel(src_sel), .step_en(step_en),
        .out_en(out_en), .decrypt(decrypt), .round_key(round_key), .kfa1(kfa1),
        .kfa2(kfa2), .kw_pre(kw_pre), .kw_post(kw_post), .dout(dout)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] b_mul(logic [7:0] a, logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] b_sub(logic [7:0] a);
        logic [7:0] v = '0;
        logic [7:0] r;
        for (int c = 1; c < 256; c++) if (b_mul(a, 8'(c)) == 8'h01) v = 8'(c);
        r = 8'h63;
        for (int n = 0; n <= 4; n++) r = r ^ ((v << n) | (v >> ((8 - n) % 8)));
        return r;
    endfunction

    function automatic logic [31:0] b_f(logic [31:0] x, logic [31:0] k);
        logic [7:0] s [4];
        logic [31:0] y;
        for (int i = 0; i < 4; i++) s[i] = b_sub(x[31-8*i -: 8]);
        for (int i = 0; i < 4; i++)
            y[31-8*i -: 8] = b_mul(s[i], 8'h02) ^ b_mul(s[(i+1)%4], 8'h03)
                           ^ s[(i+2)%4] ^ s[(i+3)%4];
        return y ^ k;
    endfunction

    function automatic logic [63:0] b_round(logic [63:0] x, logic [31:0] k);
        return {x[31:0] ^ b_f(x[63:32], k), x[63:32]};
    endfunction

    function automatic logic [63:0] b_swap(logic [63:0] x);
        return {x[31:0], x[63:32]};
    endfunction

    function automatic logic [31:0] b_rl(logic [31:0] h);
        return {h[30:0], h[31]};
    endfunction

    function automatic logic [31:0] b_rr(logic [31:0] h);
        return {h[0], h[31:1]};
    endfunction

    function automatic logic [63:0] b_fa(logic [63:0] x, logic [31:0] a, logic [31:0] b);
        logic [31:0] r = x[31:0] ^ b_rl(x[63:32] & a);
        logic [31:0] l = x[63:32] ^ (b_rr(r) & b);
        return {l, r};
    endfunction

    function automatic logic [63:0] b_fai(logic [63:0] y, logic [31:0] a, logic [31:0] b);
        logic [31:0] l = y[63:32] ^ (b_rr(y[31:0]) & b);
        logic [31:0] r = y[31:0] ^ b_rl(l & a);
        return {l, r};
    endfunction

    function automatic logic [63:0] b_encrypt(logic [63:0] pt);
        logic [63:0] s = pt ^ kw_pre;
        for (int r = 1; r <= 11; r++) begin
            if (r == 5) s = b_fa(s, kfa1, kfa2);
            if (r == 8) s = b_fai(s, kfa1, kfa2);
            s = b_round(s, ks[r-1]);
        end
        return b_swap(s) ^ kw_post;
    endfunction

    function automatic logic [63:0] lfsr(logic [63:0] x);
        logic [63:0] v = x;
        v = v ^ (v << 13); v = v ^ (v >> 7); v = v ^ (v << 17);
        return v;
    endfunction

    // ---------------- checking ----------------
    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one step after a negedge, return at the next negedge; track model
    task automatic do_step(logic [1:0] sel, logic [31:0] k, logic se, logic oe);
        logic [63:0] src, y;
        src_sel = sel; round_key = k; step_en = se; out_en = oe;
        case (sel)
            2'd0: src = din ^ kw_pre;
            2'd1: src = m_state;
            2'd2: src = decrypt ? b_swap(b_fa(b_swap(m_state), kfa1, kfa2))
                                : b_fa(m_state, kfa1, kfa2);
            default: src = decrypt ? b_swap(b_fai(b_swap(m_state), kfa1, kfa2))
                                   : b_fai(m_state, kfa1, kfa2);
        endcase
        y = b_round(src, k);
        @(negedge clk);
        if (se) m_state = y;
        if (oe) m_dout = b_swap(y) ^ kw_post;
        step_en = 1'b0; out_en = 1'b0;
    endtask

    task automatic run_block(logic [63:0] blk, logic dec, output logic [63:0] res);
        din = blk; decrypt = dec;
        for (int r = 1; r <= 11; r++) begin
            logic [1:0] s;
            s = (r == 1) ? 2'd0 : (r == 5) ? 2'd2 : (r == 8) ? 2'd3 : 2'd1;
            do_step(s, dec ? ks[11-r] : ks[r-1], 1'b1, r == 11);
        end
        res = dout;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] seed, pt, ct, back, hold_v, ekpre, ekpost;
        seed = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check64("R1 dout after reset", dout, 64'h0);
        kw_pre = '0; kw_post = '0;
        do_step(2'd1, 32'h0, 1'b0, 1'b1);
        check64("R1 state after reset (hold source)", dout, {32'h0, 32'h63636363});

        // R5: substitution sweep via replicated-byte loads (mix cancels)
        for (int v = 0; v < 256; v++) begin
            din = {{4{8'(v)}}, 32'h0};
            do_step(2'd0, 32'h0, 1'b1, 1'b1);
            check64("R5 substitution sweep", dout, {{4{8'(v)}}, {4{b_sub(8'(v))}}});
        end

        // R2 R3 R4: load with whitening and keyed round, distinct patterns
        for (int i = 0; i < 8; i++) begin
            seed = lfsr(seed); din = seed;
            seed = lfsr(seed); kw_pre = seed;
            seed = lfsr(seed); kw_post = seed;
            do_step(2'd0, seed[47:16], 1'b1, 1'b1);
            check64("R2 R3 R4 load round", dout, m_dout);
        end

        // R6: hold source
        seed = lfsr(seed);
        do_step(2'd1, seed[31:0], 1'b1, 1'b1);
        check64("R6 previous-state source", dout, m_dout);

        // R7 R8: forward and inverse mix, encrypt view
        for (int i = 0; i < 4; i++) begin
            seed = lfsr(seed); kfa1 = seed[63:32]; kfa2 = seed[31:0];
            decrypt = 1'b0;
            do_step(2'd2, seed[40:9], 1'b1, 1'b1);
            check64("R7 forward mix source", dout, m_dout);
            do_step(2'd3, seed[50:19], 1'b1, 1'b1);
            check64("R8 inverse mix source", dout, m_dout);
        end

        // R9: swapped view when decrypting
        for (int i = 0; i < 4; i++) begin
            seed = lfsr(seed); kfa1 = seed[31:0]; kfa2 = seed[63:32];
            decrypt = 1'b1;
            do_step(2'd2, seed[44:13], 1'b1, 1'b1);
            check64("R9 forward mix swapped view", dout, m_dout);
            do_step(2'd3, seed[33:2], 1'b1, 1'b1);
            check64("R9 inverse mix swapped view", dout, m_dout);
        end
        decrypt = 1'b0;

        // R10: out_en low keeps dout while state moves
        hold_v = dout;
        do_step(2'd1, 32'hA5A5_0F0F, 1'b1, 1'b0);
        do_step(2'd2, 32'h1234_5678, 1'b1, 1'b0);
        check64("R10 dout holds with out_en low", dout, hold_v);
        do_step(2'd1, 32'h0BAD_F00D, 1'b0, 1'b1);
        check64("R10 out_en captures whitened result", dout, m_dout);

        // R11: step_en low leaves state unchanged
        din = 64'hFFFF_0000_FFFF_0000;
        do_step(2'd0, 32'h7777_7777, 1'b0, 1'b0);
        do_step(2'd3, 32'h3333_3333, 1'b0, 1'b0);
        do_step(2'd1, 32'h0, 1'b0, 1'b1);
        check64("R11 state unchanged by disabled steps", dout, m_dout);

        // R12: full encrypt / decrypt round trips
        for (int b = 0; b < 6; b++) begin
            for (int r = 0; r < 11; r++) begin seed = lfsr(seed); ks[r] = seed[31:0]; end
            seed = lfsr(seed); kfa1 = seed[31:0]; kfa2 = seed[63:32];
            seed = lfsr(seed); ekpre = seed;
            seed = lfsr(seed); ekpost = seed;
            seed = lfsr(seed); pt = (b == 0) ? 64'h0 : seed;
            kw_pre = ekpre; kw_post = ekpost;
            run_block(pt, 1'b0, ct);
            check64("R12 eleven-step encryption", ct, b_encrypt(pt));
            kw_pre = ekpost; kw_post = ekpre;
            run_block(ct, 1'b1, back);
            check64("R12 decryption recovers plaintext", back, pt);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule